// File: doc/BRIEF.md
# Oversampling Bit-Clock Recovery with NRZI Word Deserializer

This block takes a demodulated binary receive line and recovers its bit timing with a digital phase-locked loop built around a programmable sample-interval timer. The timer counts base-clock cycles in units of `TICKS_PER_UNIT` and raises a one-cycle sample strobe at the end of each interval. Every bit period holds either three samples or two samples, set by the `mode_2x` input. One sample in each bit is the decision sample. On that sample the loop reads a short record of recent line transitions and picks the next interval: one unit longer, one unit shorter, or nominal. This moves the sampling phase toward the centre of the bit.

The decided levels are NRZI-decoded. A level equal to the previous decided level is a 1, and a change of level is a 0. The decoded bits are packed least-significant-bit first into `WORD_W`-bit words. Each word comes out with a one-cycle valid pulse. The block sits between an analog demodulator's slicer output and a downstream HDLC deframer, and is fed by a free-running base clock. Typical use takes 8 ticks per unit, so a bit spans 96 base ticks in either mode.

Top module: `dpll_nrzi_rx`

## Requirements
- R1: While `rst_n` is low, `sample_stb` and `word_valid` are both 0.
- R2: The gap between two sample strobes is always a whole number of units times `TICKS_PER_UNIT`. In three-sample mode (`mode_2x`=0) the gap is 3, 4 or 5 units. In two-sample mode (`mode_2x`=1) it is 5, 6 or 7 units.
- R3: While the line holds one level, every gap is nominal: 4 units in three-sample mode and 6 units in two-sample mode.
- R4: In three-sample mode the first strobe after reset is a decision sample, and every third strobe after it is one too. With the line held at 0 from reset, the first word follows the 46th strobe.
- R5: In two-sample mode strobes alternate between decision and intermediate, starting with a decision. With the line held at 0 from reset, the first word follows the 31st strobe.
- R6: NRZI decoding: a decided level equal to the previous one gives bit 1 and a change gives bit 0. The previous level is 0 after reset. A steady 0 line yields words 0xFFFF, and a line that toggles every bit yields words 0x0000.
- R7: A word is emitted after every 16 decisions. The first decided bit goes to bit 0. `word_valid` is a single-cycle pulse in the cycle after the decision strobe.
- R8: In three-sample mode, after a preamble of toggling bits, a 48-bit payload sent with bit periods that drift by one unit either way is recovered exactly.
- R9: The same recovery as R8 holds in two-sample mode.
- R10: `sample_stb` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_2x | input | 1 | 0: three samples per bit, 1: two samples per bit |
| rx_line | input | 1 | Demodulated receive line, asynchronous |
| sample_stb | output | 1 | One-cycle pulse at each sample point |
| word_valid | output | 1 | One-cycle pulse when `word_data` holds a new word |
| word_data | output | 16 | Decoded word, first received bit in bit 0 |

## Verification
On every cycle the assertions check that strobe gaps fall within the legal set for the current mode, that strobes and word pulses never last two cycles, and that every word pulse directly follows a strobe. The assertions cannot show lock, decision-phase ordering or decoded content. Only the scenarios show these: the strobe count to the first word, the exact words on a steady or toggling line, and payload recovery under drifting bit periods in each mode.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef logic [2:0] units_t;

  typedef enum logic {
    OVS_3X = 1'b0,
    OVS_2X = 1'b1
  } ovs_mode_e;

  localparam int MAX_UNITS = 7;

  // Next sample interval in units, given the mode, whether this is the
  // decision sample, and the three newest transition flags (bit 0 newest).
  function automatic units_t pick_interval(ovs_mode_e m, logic is_dec, logic [2:0] h);
    units_t u;
    if (m == OVS_3X) begin
      u = 3'd4;
      if (is_dec) begin
        if (h == 3'b001)      u = 3'd5;
        else if (h == 3'b100) u = 3'd3;
      end
    end else begin
      u = 3'd6;
      if (is_dec) begin
        if (h[1:0] == 2'b01)      u = 3'd7;
        else if (h[1:0] == 2'b10) u = 3'd5;
      end
    end
    return u;
  endfunction

endpackage

// File: rtl/dpll_interval_timer.sv
module dpll_interval_timer
  import dpll_pkg::*;
#(
  parameter int TICKS = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  units_t interval_units,
  output logic   stb
);

  localparam int CNT_W = $clog2(MAX_UNITS * TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q;

  always_comb begin
    stb   = armed_q && (cnt_q == '0);
    cnt_d = cnt_q;
    if (stb)
      cnt_d = CNT_W'(interval_units) * CNT_W'(TICKS) - CNT_W'(1);
    else if (armed_q)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/dpll_phase_ctl.sv
module dpll_phase_ctl
  import dpll_pkg::*;
#(
  parameter int HIST_W = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      stb,
  input  ovs_mode_e mode,
  input  logic      sample,
  output logic      decide,
  output units_t    interval_units
);

  logic [HIST_W-1:0] hist_q, hist_d;
  logic              prev_q;
  logic [1:0]        phase_q, phase_d, phase_last;
  logic              is_dec;

  always_comb begin
    hist_d         = {hist_q[HIST_W-2:0], sample ^ prev_q};
    is_dec         = (phase_q == 2'd0);
    decide         = stb && is_dec;
    interval_units = pick_interval(mode, is_dec, hist_d[2:0]);
    phase_last     = (mode == OVS_2X) ? 2'd1 : 2'd2;
    phase_d        = (phase_q >= phase_last) ? 2'd0 : phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      prev_q  <= 1'b0;
      phase_q <= 2'd0;
    end else if (stb) begin
      hist_q  <= hist_d;
      prev_q  <= sample;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/dpll_nrzi_deser.sv
module dpll_nrzi_deser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decide,
  input  logic              sample,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);

  localparam logic [WORD_W:0] MARK = {1'b1, {WORD_W{1'b0}}};

  logic [WORD_W:0]   acc_q, acc_d, shifted;
  logic              level_q;
  logic              valid_d;
  logic [WORD_W-1:0] word_q, word_d;

  always_comb begin
    shifted = {sample == level_q, acc_q[WORD_W:1]};
    acc_d   = acc_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (decide) begin
      if (shifted[0]) begin
        word_d  = shifted[WORD_W:1];
        valid_d = 1'b1;
        acc_d   = MARK;
      end else begin
        acc_d = shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= MARK;
      level_q    <= 1'b0;
      word_q     <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= valid_d;
      word_q     <= word_d;
      acc_q      <= acc_d;
      if (decide) level_q <= sample;
    end
  end

  assign word_data = word_q;

endmodule

// File: rtl/dpll_nrzi_rx.sv
module dpll_nrzi_rx
  import dpll_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 8,
  parameter int WORD_W         = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_2x,
  input  logic              rx_line,
  output logic              sample_stb,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   decide;
  units_t                 next_units;
  ovs_mode_e              mode;

  assign mode = ovs_mode_e'(mode_2x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  dpll_interval_timer #(.TICKS(TICKS_PER_UNIT)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .interval_units (next_units),
    .stb            (sample_stb)
  );

  dpll_phase_ctl #(.HIST_W(5)) u_phase (
    .clk            (clk),
    .rst_n          (rst_n),
    .stb            (sample_stb),
    .mode           (mode),
    .sample         (rx_s),
    .decide         (decide),
    .interval_units (next_units)
  );

  dpll_nrzi_deser #(.WORD_W(WORD_W)) u_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .decide     (decide),
    .sample     (rx_s),
    .word_valid (word_valid),
    .word_data  (word_data)
  );

endmodule

// File: rtl/dpll_nrzi_rx_chk.sv
module dpll_nrzi_rx_chk #(
  parameter int TICKS_PER_UNIT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic mode_2x,
  input logic sample_stb,
  input logic word_valid
);

  localparam int GAP_W = $clog2(8 * TICKS_PER_UNIT + 2);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic             gap_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sample_stb) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  always_comb begin
    if (mode_2x)
      gap_ok = (32'(gap_q) == 5 * TICKS_PER_UNIT) || (32'(gap_q) == 6 * TICKS_PER_UNIT) ||
               (32'(gap_q) == 7 * TICKS_PER_UNIT);
    else
      gap_ok = (32'(gap_q) == 3 * TICKS_PER_UNIT) || (32'(gap_q) == 4 * TICKS_PER_UNIT) ||
               (32'(gap_q) == 5 * TICKS_PER_UNIT);
  end

  // R2: every strobe gap is one of the legal intervals of the mode
  a_r2_gap_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && seen_q) |-> gap_ok);

  // R10: strobe lasts one cycle
  a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R7: word pulse lasts one cycle
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R7: a word pulse always follows a decision strobe
  a_r7_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(sample_stb));

endmodule

bind dpll_nrzi_rx dpll_nrzi_rx_chk #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_2x    (mode_2x),
  .sample_stb (sample_stb),
  .word_valid (word_valid)
);

// File: tb/sim_dpll_nrzi_rx.sv
`timescale 1ns/1ps
module sim_dpll_nrzi_rx;

  localparam int TPU = 8;
  localparam int BITP = 12 * TPU;

  logic        clk;
  logic        rst_n;
  logic        mode_2x;
  logic        rx_line;
  logic        sample_stb;
  logic        word_valid;
  logic [15:0] word_data;

  int checks;
  int errors;

  // monitor state
  int   stb_cnt, gcnt, seen_stb;
  int   bad_gap, off_nominal, wide_valid;
  int   first_word_stb, nwords, zero_words;
  logic [15:0] first_word;
  logic prev_valid;
  logic rxbits [0:2047];
  int   nbits;
  logic level;

  localparam logic [47:0] PAYLOAD = 48'hA5C3_0F96_7E21;

  dpll_nrzi_rx #(.TICKS_PER_UNIT(TPU), .WORD_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_2x(mode_2x), .rx_line(rx_line),
    .sample_stb(sample_stb), .word_valid(word_valid), .word_data(word_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_stb) begin
        stb_cnt = stb_cnt + 1;
        if (seen_stb != 0) begin
          if (mode_2x ? !(gcnt == 5*TPU || gcnt == 6*TPU || gcnt == 7*TPU)
                      : !(gcnt == 3*TPU || gcnt == 4*TPU || gcnt == 5*TPU))
            bad_gap = bad_gap + 1;
          if (gcnt != (mode_2x ? 6*TPU : 4*TPU)) off_nominal = off_nominal + 1;
        end
        seen_stb = 1;
        gcnt = 1;
      end else begin
        gcnt = gcnt + 1;
      end
      if (word_valid) begin
        if (prev_valid) wide_valid = wide_valid + 1;
        if (nwords == 0) begin
          first_word     = word_data;
          first_word_stb = stb_cnt;
        end
        if (word_data == 16'h0000) zero_words = zero_words + 1;
        nwords = nwords + 1;
        for (int i = 0; i < 16; i++) begin
          if (nbits < 2048) begin
            rxbits[nbits] = word_data[i];
            nbits = nbits + 1;
          end
        end
      end
      prev_valid = word_valid;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    stb_cnt = 0; gcnt = 0; seen_stb = 0; bad_gap = 0; off_nominal = 0;
    wide_valid = 0; first_word_stb = 0; nwords = 0; zero_words = 0;
    first_word = 16'h0; prev_valid = 1'b0; nbits = 0;
  endtask

  task automatic do_reset(input logic m);
    mode_2x = m;
    rx_line = 1'b0;
    level   = 1'b0;
    rst_n   = 1'b0;
    repeat (5) @(negedge clk);
    clear_mon();
    rst_n = 1'b1;
  endtask

  task automatic t_reset_quiet();
    mode_2x = 1'b0;
    rx_line = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    check(sample_stb == 1'b0, "R1 stb in reset", int'(sample_stb), 0);
    check(word_valid == 1'b0, "R1 valid in reset", int'(word_valid), 0);
  endtask

  // steady 0 line from reset: nominal gaps, decision ordering, 0xFFFF words
  task automatic t_idle(input logic m, input int exp_stb, input string rtag);
    do_reset(m);
    while (nwords < 3) @(negedge clk);
    check(off_nominal == 0, "R3 idle gaps nominal", off_nominal, 0);
    check(first_word_stb == exp_stb, {rtag, " strobes before first word"}, first_word_stb, exp_stb);
    check(first_word == 16'hFFFF, "R6 steady line word", int'(first_word), 16'hFFFF);
    check(wide_valid == 0, "R7 valid single cycle", wide_valid, 0);
    check(bad_gap == 0, "R2 idle gaps legal", bad_gap, 0);
  endtask

  task automatic send_bit(input logic b, input int per);
    if (!b) level = ~level;
    rx_line = level;
    repeat (per) @(negedge clk);
  endtask

  task automatic t_stream(input logic m, input string rtag);
    int per [4];
    int k;
    int found;
    logic ok;
    per[0] = BITP; per[1] = BITP + TPU; per[2] = BITP; per[3] = BITP - TPU;
    do_reset(m);
    repeat (10 * BITP) @(negedge clk);
    k = 0;
    for (int i = 0; i < 32; i++) begin send_bit(1'b0, per[k % 4]); k++; end
    for (int i = 0; i < 48; i++) begin send_bit(PAYLOAD[i], per[k % 4]); k++; end
    for (int i = 0; i < 48; i++) begin send_bit(1'b0, per[k % 4]); k++; end
    repeat (2 * BITP) @(negedge clk);
    found = 0;
    for (int off = 0; off + 48 <= nbits; off++) begin
      ok = 1'b1;
      for (int j = 0; j < 48; j++)
        if (rxbits[off + j] !== PAYLOAD[j]) ok = 1'b0;
      if (ok) found = 1;
    end
    check(found == 1, {rtag, " payload recovered under drift"}, found, 1);
    check(bad_gap == 0, "R2 stream gaps legal", bad_gap, 0);
    check(zero_words > 0, "R6 toggling line gives 0x0000", zero_words, 1);
    check(wide_valid == 0, "R7 valid single cycle stream", wide_valid, 0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    clear_mon();
    mode_2x = 1'b0;
    rx_line = 1'b0;
    level   = 1'b0;
    rst_n   = 1'b0;
    t_reset_quiet();
    t_idle(1'b0, 46, "R4");
    t_idle(1'b1, 31, "R5");
    t_stream(1'b0, "R8");
    t_stream(1'b1, "R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule